// File: doc/BRIEF.md
# Double-Buffered SPI Master

A full-duplex serial master controller driven by a processor through a small register file. The processor chooses a chip-select index and then writes a byte into a transmit holding register. If the shift engine is free, the byte moves into the shifter on the next clock and goes out on MOSI, most significant bit first. At the same time, MISO is sampled into the same shifter. When the byte is complete, the received byte lands in a receive register. A byte written while a transfer is running waits in the holding register and goes out straight after the current one, so a steady stream needs only one register write per byte.

The serial clock runs in mode 0: it idles low, data changes on the falling edge, and data is sampled on the rising edge. Each half period lasts a programmable number of system clocks. An optional gap, counted in units of 32 system clocks, follows every byte, and the chip select stays asserted through it. Four status flags report the transfer state: holding register empty, engine fully idle, received byte ready, and receive overrun.

Register map (3-bit address): 0 control (bit 0 enable), 1 chip-select index, 2 clock divider, 3 gap length, 4 data (a write loads the holding register, a read returns the receive register), 5 status. The status bits are: bit 0 holding empty, bit 1 idle, bit 2 receive ready, bit 3 overrun.

Top module: `spi_dbuf_master`

## Requirements
- R1: After reset the status register (address 5) reads 0x03, the control register reads 0, every cs_n_o bit is high, and sclk_o and mosi_o are low.
- R2: While control bit 0 is clear, a write to address 4 has no effect: status stays 0x03, no chip select asserts, and sclk_o stays low.
- R3: When the engine is idle, a data write clears status bit 0 after the write edge. The byte enters the shifter on the next edge, which sets bit 0 again. Receive-ready (bit 2) first reads 1 exactly 16·DIV+2 negedge samples after the data is driven.
- R4: sclk_o idles low, and each high or low phase lasts DIV system clocks (a DIV of 0 acts as 1). A byte has 8 high phases, 8·DIV clocks in total.
- R5: The transmit byte appears on mosi_o MSB first and changes only after a falling sclk edge. MISO is sampled on rising edges, and the received byte holds the MISO bits MSB first.
- R6: The chip-select index written to address 1 is captured with each data write. Only cs_n_o[index] goes low (active low), from the load until the end of the gap. All cs_n_o bits are high when the engine is idle.
- R7: A byte written during a transfer stays in the holding register, so status bit 0 reads 0. With a gap of 0 it starts on the same edge that ends the current byte, and the two completions are 16·DIV clocks apart.
- R8: With gap value G > 0, idle (status bit 1) rises G·32 clocks after receive-ready rises, and chip select stays low in the meantime. A held byte loads G·32 clocks after the previous completion.
- R9: Receive-ready sets when a byte completes. A read of address 4 returns that byte and clears receive-ready.
- R10: A completion while receive-ready is set sets overrun (bit 3) and overwrites the receive register. Reading address 4 leaves overrun set, and only a read of address 5 clears it.
- R11: Status bit 1 is set only when no byte is held and the engine is neither shifting nor in a gap.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects on the clock edge) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational from addr_i |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 4 | Chip selects, active low |

## Verification
The bench uses the default build: 8-bit words, four chip selects and a 32-clock gap unit. It sweeps the divider from 1 to 4 and the gap from 0 to 2, and rotates through every chip-select index, so that all of the timing formulas are checked on short runs. A loopback slave returns the previous byte, which exposes bit order and sampling edges. Two chained runs, one with a gap and one without, cover holding, back-to-back loading and overrun.

// File: rtl/spi_dbuf_pkg.sv
package spi_dbuf_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_CSEL = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd2;
  localparam logic [ADDR_W-1:0] A_GAP  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATA = 3'd4;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd5;

  localparam int SB_TXE = 0;
  localparam int SB_IDL = 1;
  localparam int SB_RXF = 2;
  localparam int SB_OVR = 3;

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_SHIFT = 2'd1,
    ENG_GAP   = 2'd2
  } eng_state_e;
endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div_i == '0) ? DIV_W'(1) : div_i;
  // >= keeps the count bounded if the divider shrinks mid-transfer
  assign tick_o  = run_i && (cnt_q >= div_eff - DIV_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + DIV_W'(1);
  end

  AST_IDLE_NO_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |-> !tick_o); // R4
endmodule

// File: rtl/spi_shift_eng.sv
module spi_shift_eng
  import spi_dbuf_pkg::*;
#(
  parameter int W        = 8,
  parameter int IDX_W    = 2,
  parameter int GAP_IN_W = 8,
  parameter int GAP_UNIT = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                tick_i,
  input  logic                hold_valid_i,
  input  logic [W-1:0]        hold_data_i,
  input  logic [IDX_W-1:0]    hold_cs_i,
  input  logic [GAP_IN_W-1:0] gap_i,
  input  logic                miso_i,
  output logic                take_o,
  output logic                done_o,
  output logic [W-1:0]        rx_word_o,
  output logic                run_o,
  output logic                active_o,
  output logic                idle_o,
  output logic [IDX_W-1:0]    cs_idx_o,
  output logic                sclk_o,
  output logic                mosi_o
);
  localparam int CNT_W = $clog2(W);
  localparam int GAP_W = GAP_IN_W + $clog2(GAP_UNIT) + 1;

  eng_state_e       state_q;
  logic [W-1:0]     shreg_q;
  logic [CNT_W-1:0] bit_q;
  logic             miso_q;
  logic             sclk_q;
  logic [GAP_W-1:0] gap_q;
  logic [IDX_W-1:0] cs_q;

  logic last_fall;
  logic gap_end;

  assign last_fall = (state_q == ENG_SHIFT) && tick_i && sclk_q && (bit_q == CNT_W'(W-1));
  assign gap_end   = (state_q == ENG_GAP) && (gap_q == '0);
  // loads from idle, back-to-back on the last falling edge, or at the end of the gap
  assign take_o    = hold_valid_i &&
                     ((state_q == ENG_IDLE) || (last_fall && gap_i == '0) || gap_end);

  assign done_o    = last_fall;
  assign rx_word_o = {shreg_q[W-2:0], miso_q};
  assign run_o     = (state_q == ENG_SHIFT);
  assign active_o  = (state_q != ENG_IDLE);
  assign idle_o    = (state_q == ENG_IDLE);
  assign cs_idx_o  = cs_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = (state_q == ENG_SHIFT) ? shreg_q[W-1] : 1'b0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ENG_IDLE;
      shreg_q <= '0;
      bit_q   <= '0;
      miso_q  <= 1'b0;
      sclk_q  <= 1'b0;
      gap_q   <= '0;
      cs_q    <= '0;
    end else if (take_o) begin
      state_q <= ENG_SHIFT;
      shreg_q <= hold_data_i;
      bit_q   <= '0;
      sclk_q  <= 1'b0;
      cs_q    <= hold_cs_i;
    end else begin
      unique case (state_q)
        ENG_SHIFT: begin
          if (tick_i) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              miso_q <= miso_i;
            end else begin
              sclk_q  <= 1'b0;
              shreg_q <= {shreg_q[W-2:0], miso_q};
              bit_q   <= bit_q + CNT_W'(1);
              if (bit_q == CNT_W'(W-1)) begin
                if (gap_i != '0) begin
                  state_q <= ENG_GAP;
                  gap_q   <= GAP_W'(gap_i) * GAP_W'(GAP_UNIT) - GAP_W'(1);
                end else begin
                  state_q <= ENG_IDLE;
                end
              end
            end
          end
        end
        ENG_GAP: begin
          if (gap_q == '0) state_q <= ENG_IDLE;
          else             gap_q   <= gap_q - GAP_W'(1);
        end
        default: ;
      endcase
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ENG_SHIFT) |-> !sclk_o); // R4
  AST_SCLK_ONLY_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENG_SHIFT && !tick_i && !take_o) |=> $stable(sclk_o)); // R4
  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENG_SHIFT && sclk_q && !tick_i) |=> $stable(mosi_o)); // R5
  AST_GAP_HOLDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ENG_GAP && gap_q != '0) |=> active_o); // R8
endmodule

// File: rtl/spi_cs_dec.sv
module spi_cs_dec #(
  parameter int NUM_CS = 4,
  parameter int IDX_W  = 2
) (
  input  logic              active_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
    assign cs_n_o[g] = !(active_i && (idx_i == IDX_W'(g)));
  end

  always_comb begin
    AST_CS_ONEHOT: assert ($countones(~cs_n_o) <= 1); // R6
  end
endmodule

// File: rtl/spi_dbuf_master.sv
module spi_dbuf_master
  import spi_dbuf_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_CS   = 4,
  parameter int GAP_UNIT = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NUM_CS-1:0] cs_n_o
);
  localparam int IDX_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1;

  logic              enable_q;
  logic [IDX_W-1:0]  csel_q;
  logic [DATA_W-1:0] div_q;
  logic [DATA_W-1:0] gap_q;
  logic              hold_valid_q;
  logic [DATA_W-1:0] hold_data_q;
  logic [IDX_W-1:0]  hold_cs_q;
  logic [DATA_W-1:0] rx_q;
  logic              rx_full_q;
  logic              ovr_q;

  logic              tick, take, done, run, active, eng_idle;
  logic [DATA_W-1:0] rx_word;
  logic [IDX_W-1:0]  cs_idx;
  logic              wr_data, rd_rx, rd_stat, idle_flag;
  logic [DATA_W-1:0] status;

  assign wr_data   = wr_en_i && (addr_i == A_DATA) && enable_q;
  assign rd_rx     = rd_en_i && (addr_i == A_DATA);
  assign rd_stat   = rd_en_i && (addr_i == A_STAT);
  assign idle_flag = eng_idle && !hold_valid_q;

  always_comb begin
    status         = '0;
    status[SB_TXE] = !hold_valid_q;
    status[SB_IDL] = idle_flag;
    status[SB_RXF] = rx_full_q;
    status[SB_OVR] = ovr_q;
  end

  always_comb begin
    unique case (addr_i)
      A_CTRL:  rdata_o = DATA_W'(enable_q);
      A_CSEL:  rdata_o = DATA_W'(csel_q);
      A_DIV:   rdata_o = div_q;
      A_GAP:   rdata_o = gap_q;
      A_DATA:  rdata_o = rx_q;
      A_STAT:  rdata_o = status;
      default: rdata_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enable_q <= 1'b0;
      csel_q   <= '0;
      div_q    <= DATA_W'(1);
      gap_q    <= '0;
    end else if (wr_en_i) begin
      unique case (addr_i)
        A_CTRL:  enable_q <= wdata_i[0];
        A_CSEL:  csel_q   <= wdata_i[IDX_W-1:0];
        A_DIV:   div_q    <= wdata_i;
        A_GAP:   gap_q    <= wdata_i;
        default: ;
      endcase
    end
  end

  // holding register: a new write wins over a same-cycle load into the shifter
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_valid_q <= 1'b0;
      hold_data_q  <= '0;
      hold_cs_q    <= '0;
    end else if (wr_data) begin
      hold_valid_q <= 1'b1;
      hold_data_q  <= wdata_i;
      hold_cs_q    <= csel_q;
    end else if (take) begin
      hold_valid_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q      <= '0;
      rx_full_q <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      if (done) rx_q <= rx_word;
      if (done)       rx_full_q <= 1'b1;
      else if (rd_rx) rx_full_q <= 1'b0;
      if (done && rx_full_q && !rd_rx) ovr_q <= 1'b1;
      else if (rd_stat)                ovr_q <= 1'b0;
    end
  end

  spi_baud_gen #(.DIV_W(DATA_W)) u_baud (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .div_i (div_q),
    .tick_o(tick)
  );

  spi_shift_eng #(
    .W       (DATA_W),
    .IDX_W   (IDX_W),
    .GAP_IN_W(DATA_W),
    .GAP_UNIT(GAP_UNIT)
  ) u_eng (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick),
    .hold_valid_i(hold_valid_q),
    .hold_data_i (hold_data_q),
    .hold_cs_i   (hold_cs_q),
    .gap_i       (gap_q),
    .miso_i      (miso_i),
    .take_o      (take),
    .done_o      (done),
    .rx_word_o   (rx_word),
    .run_o       (run),
    .active_o    (active),
    .idle_o      (eng_idle),
    .cs_idx_o    (cs_idx),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o)
  );

  spi_cs_dec #(.NUM_CS(NUM_CS), .IDX_W(IDX_W)) u_cs (
    .active_i(active),
    .idx_i   (cs_idx),
    .cs_n_o  (cs_n_o)
  );

  AST_TXE_CLEARS_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_data |=> !status[SB_TXE]); // R3
  AST_DISABLED_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!enable_q && wr_en_i && addr_i == A_DATA && !hold_valid_q) |=> !hold_valid_q); // R2
  AST_RXF_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> rx_full_q); // R9
  AST_OVR_ON_DOUBLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done && rx_full_q && !rd_rx) |=> ovr_q); // R10
  AST_OVR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovr_q && !rd_stat) |=> ovr_q); // R10
  AST_IDLE_NO_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_flag |-> (&cs_n_o && !sclk_o)); // R11
endmodule

// File: tb/tb_spi_dbuf_master.sv
module tb_spi_dbuf_master;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic       rd_en_i = 1'b0;
  logic [2:0] addr_i = 3'd0;
  logic [7:0] wdata_i = 8'd0;
  logic [7:0] rdata_o;
  logic       sclk_o, mosi_o, miso_i;
  logic [3:0] cs_n_o;

  int checks = 0;
  int errors = 0;

  always #5 clk_i = ~clk_i;

  spi_dbuf_master dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .sclk_o(sclk_o), .mosi_o(mosi_o), .miso_i(miso_i), .cs_n_o(cs_n_o)
  );

  // loopback slave: returns the byte it received in the previous transfer
  logic [7:0] sreg = 8'h3C;
  logic       s_in = 1'b0;
  always @(posedge sclk_o) s_in <= mosi_o;
  always @(negedge sclk_o) sreg <= {sreg[6:0], s_in};
  assign miso_i = sreg[7];

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic peek(output logic [7:0] s);
    addr_i = 3'd5;
    #1 s = rdata_o;
  endtask

  logic [7:0] prev_tx = 8'h3C;

  task automatic single_xfer(input int div, input int gap, input int cs, input logic [7:0] data);
    logic [7:0] st, rd;
    int n, hi, cs_bad, m;
    logic [3:0] cs_exp;
    cs_exp = ~(4'b0001 << cs);
    reg_wr(3'd2, 8'(div));
    reg_wr(3'd3, 8'(gap));
    reg_wr(3'd1, 8'(cs));
    reg_wr(3'd4, data);
    n = 1; hi = 0; cs_bad = 0;
    peek(st);
    chk("R3 txe clear after write", int'(st[0]), 0);
    if (sclk_o) hi++;
    @(negedge clk_i); n++; peek(st);
    chk("R3 txe set after load", int'(st[0]), 1);
    while (!st[2] && n < 5000) begin
      if (sclk_o) hi++;
      if (cs_n_o != cs_exp) cs_bad++;
      @(negedge clk_i); n++; peek(st);
    end
    chk("R3 completion time", n, 16 * div + 2);
    chk("R4 sclk high clocks", hi, 8 * div);
    chk("R6 cs pattern during transfer", cs_bad, 0);
    m = 0; cs_bad = 0;
    while (!st[1] && m < 10000) begin
      if (cs_n_o != cs_exp) cs_bad++;
      @(negedge clk_i); m++; peek(st);
    end
    chk("R8 idle after gap", m, gap * 32);
    chk("R8 cs held through gap", cs_bad, 0);
    chk("R6 cs released when idle", int'(cs_n_o), 4'hF);
    chk("R5 slave saw byte MSB first", int'(sreg), int'(data));
    reg_rd(3'd4, rd);
    chk("R5 received byte", int'(rd), int'(prev_tx));
    prev_tx = data;
    peek(st);
    chk("R9 rx ready cleared by read", int'(st[2]), 0);
  endtask

  task automatic chain_xfer(input int gap, input int cs, input logic [7:0] a, input logic [7:0] b);
    logic [7:0] st, rd;
    int k, k_txe, guard;
    reg_wr(3'd2, 8'd2);
    reg_wr(3'd3, 8'(gap));
    reg_wr(3'd1, 8'(cs));
    reg_wr(3'd4, a);
    reg_wr(3'd4, b);
    peek(st);
    chk("R7 second byte held", int'(st[0]), 0);
    guard = 0;
    while (!st[2] && guard < 5000) begin
      @(negedge clk_i); guard++; peek(st);
    end
    chk("R11 not idle with byte held", int'(st[1]), 0);
    k = 0; k_txe = st[0] ? 0 : -1;
    while (!st[3] && k < 5000) begin
      @(negedge clk_i); k++; peek(st);
      if (k_txe < 0 && st[0]) k_txe = k;
    end
    chk("R8 held byte loads after gap", k_txe, gap * 32);
    chk("R7 back-to-back spacing", k, gap * 32 + 32);
    chk("R10 rx ready still set", int'(st[2]), 1);
    reg_rd(3'd4, rd);
    chk("R10 rx overwritten by newest", int'(rd), int'(a));
    reg_rd(3'd5, st);
    chk("R10 overrun kept after rx read", int'(st[3]), 1);
    chk("R9 rx ready cleared", int'(st[2]), 0);
    reg_rd(3'd5, st);
    chk("R10 overrun cleared by status read", int'(st[3]), 0);
    guard = 0;
    peek(st);
    while (!st[1] && guard < 5000) begin
      @(negedge clk_i); guard++; peek(st);
    end
    chk("R5 slave holds last byte", int'(sreg), int'(b));
    prev_tx = b;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] st, rd;
    int idx;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    peek(st);
    chk("R1 status after reset", int'(st), 8'h03);
    chk("R1 cs idle", int'(cs_n_o), 4'hF);
    chk("R1 sclk low", int'(sclk_o), 0);
    chk("R1 mosi low", int'(mosi_o), 0);
    reg_rd(3'd0, rd);
    chk("R1 control reset", int'(rd), 0);

    reg_wr(3'd4, 8'h55);
    repeat (5) @(negedge clk_i);
    peek(st);
    chk("R2 status unchanged when disabled", int'(st), 8'h03);
    chk("R2 no cs when disabled", int'(cs_n_o), 4'hF);
    chk("R2 no sclk when disabled", int'(sclk_o), 0);

    reg_wr(3'd0, 8'h01);
    idx = 0;
    for (int div = 1; div <= 4; div++) begin
      for (int gap = 0; gap <= 2; gap++) begin
        single_xfer(div, gap, idx % 4, 8'hA5 ^ 8'(div * 37 + gap * 11 + idx));
        idx++;
      end
    end
    chain_xfer(0, 3, 8'hC3, 8'h81);
    chain_xfer(1, 1, 8'h0F, 8'hE6);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule